// File: doc/BRIEF.md
# Register-to-DRP Access Bridge

This block sits between a processor's 32-bit register port and the 16-bit dynamic reconfiguration port of a clock-synthesis primitive. Software writes one control word that carries the whole transaction: a start flag, a read/write choice, a 7-bit register address and 16 bits of write data. The bridge issues a single enable pulse on the reconfiguration port. It then holds a busy flag until the port's ready strobe comes back.

Software polls a status word until busy is clear. For a read, the low half of that word then holds the data that came back. A read-modify-write is two separate transactions, and each waits for busy to clear. The same register port also holds a small control register, whose two bits release the general reset and enable the primitive, and a select register that chooses the input clock source.

Top module: `regdrp_bridge`

## Requirements
- R1: After a synchronous reset, every mapped register reads zero, busy is clear, and all outputs are low.
- R2: The register at offset 0x40 stores write data bits 1:0 and reads them back in bits 1:0. Bit 0 drives `core_rel` and bit 1 drives `prim_en`. Writing 0x1 sets `core_rel` and leaves `prim_en` low.
- R3: The register at offset 0x44 stores the low SEL_W bits of the write data, drives `clk_sel` with them and reads them back. The upper bits read zero.
- R4: A write to offset 0x70 with bit 29 set, made while busy is clear, starts a transaction. In the next cycle busy is set and `drp_en` is high for exactly one cycle. In that cycle `drp_addr` equals bits 22:16 and `drp_di` equals bits 15:0. `drp_we` is high in that cycle only when bit 28 is clear.
- R5: Busy stays set until `drp_rdy` is seen high in a cycle after the enable pulse. Busy reads clear in the cycle after that strobe.
- R6: When bit 28 is set, the transaction is a read: `drp_we` stays low, and the value on `drp_do` in the ready cycle appears in status bits 15:0 when busy clears. A write transaction leaves status bits 15:0 unchanged.
- R7: A write to offset 0x70 while busy is set is ignored. No new enable pulse follows, and the address and data outputs keep their values.
- R8: A write to offset 0x70 with bit 29 clear starts no transaction and does not change the control readback.
- R9: Control bits 27:23 have no effect on `drp_addr`. Reading offset 0x70 returns bit 28, bits 22:16 and bits 15:0 of the last accepted word, with all other bits zero.
- R10: The status register at offset 0x74 has busy in bit 16 and read data in bits 15:0, with all other bits zero. Writes to it have no effect.
- R11: Reads of an unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| core_rel | output | 1 | General reset release |
| prim_en | output | 1 | Clock primitive enable |
| clk_sel | output | SEL_W | Input clock source index |
| drp_addr | output | 7 | Reconfiguration register address |
| drp_di | output | 16 | Reconfiguration write data |
| drp_do | input | 16 | Reconfiguration read data |
| drp_en | output | 1 | One-cycle transaction enable |
| drp_we | output | 1 | Write enable, valid with `drp_en` |
| drp_rdy | input | 1 | Transaction done strobe |

## Verification
Transactions are driven with reconfiguration latencies of one and several cycles. These separate a busy flag that ends on the ready strobe from one that ends after a fixed time. A write followed by a read of the same address through a memory-backed responder shows that address, data and direction are carried correctly. It also shows that only reads refresh the status data. Control words sent while busy, words with the start flag clear, and words with junk in the ignored bits tell the acceptance rules apart. A behavioural model compared on every clock catches any stray or doubled enable pulse.

// File: rtl/regdrp_pkg.sv
package regdrp_pkg;
    localparam int DRP_AW = 7;
    localparam int DRP_DW = 16;

    localparam logic [7:0] OFS_RSTCTL = 8'h40;
    localparam logic [7:0] OFS_CLKSEL = 8'h44;
    localparam logic [7:0] OFS_CTRL   = 8'h70;
    localparam logic [7:0] OFS_STAT   = 8'h74;

    localparam int START_BIT = 29;
    localparam int READ_BIT  = 28;
    localparam int ADDR_LSB  = 16;
    localparam int BUSY_BIT  = 16;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } drp_phase_e;

    typedef struct packed {
        logic              rd;
        logic [DRP_AW-1:0] addr;
        logic [DRP_DW-1:0] data;
    } drp_cmd_t;

    function automatic drp_cmd_t unpack_ctrl(input logic [31:0] w);
        drp_cmd_t c;
        c.rd   = w[READ_BIT];
        c.addr = w[ADDR_LSB +: DRP_AW];
        c.data = w[DRP_DW-1:0];
        return c;
    endfunction

    function automatic logic [31:0] pack_ctrl(input drp_cmd_t c);
        logic [31:0] w;
        w = '0;
        w[READ_BIT] = c.rd;
        w[ADDR_LSB +: DRP_AW] = c.addr;
        w[DRP_DW-1:0] = c.data;
        return w;
    endfunction
endpackage

// File: rtl/regdrp_cfg.sv
module regdrp_cfg #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_rstctl,
    input  logic             wr_clksel,
    input  logic [1:0]       wdata_rst,
    input  logic [SEL_W-1:0] wdata_sel,
    output logic [1:0]       rstctl_q,
    output logic [SEL_W-1:0] clksel_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rstctl_q <= '0;
            clksel_q <= '0;
        end else begin
            if (wr_rstctl) rstctl_q <= wdata_rst;
            if (wr_clksel) clksel_q <= wdata_sel;
        end
    end
endmodule

// File: rtl/regdrp_engine.sv
module regdrp_engine
    import regdrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  drp_cmd_t          cmd_in,
    input  logic              drp_rdy,
    input  logic [DRP_DW-1:0] drp_do,
    output logic              busy,
    output drp_cmd_t          cmd_q,
    output logic [DRP_DW-1:0] rd_data,
    output logic              drp_en,
    output logic              drp_we
);
    drp_phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cmd_q   <= '0;
            rd_data <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_ISSUE;
                        cmd_q   <= cmd_in;
                    end
                end
                PH_ISSUE: phase_q <= PH_WAIT;
                PH_WAIT: begin
                    if (drp_rdy) begin
                        phase_q <= PH_IDLE;
                        if (cmd_q.rd) rd_data <= drp_do;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy   = (phase_q != PH_IDLE);
    assign drp_en = (phase_q == PH_ISSUE);
    assign drp_we = (phase_q == PH_ISSUE) && !cmd_q.rd;
endmodule

// File: rtl/regdrp_bridge.sv
module regdrp_bridge
    import regdrp_pkg::*;
#(
    parameter int AW    = 8,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              core_rel,
    output logic              prim_en,
    output logic [SEL_W-1:0]  clk_sel,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    input  logic [DRP_DW-1:0] drp_do,
    output logic              drp_en,
    output logic              drp_we,
    input  logic              drp_rdy
);
    localparam logic [AW-1:0] A_RSTCTL = AW'(OFS_RSTCTL);
    localparam logic [AW-1:0] A_CLKSEL = AW'(OFS_CLKSEL);
    localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_STAT   = AW'(OFS_STAT);

    logic              busy;
    logic              start;
    logic [1:0]        rstctl_q;
    drp_cmd_t          cmd_q;
    logic [DRP_DW-1:0] rd_data;
    logic              unused_bits;

    assign unused_bits = ^{reg_wdata[31:START_BIT+1], reg_wdata[READ_BIT-1:ADDR_LSB+DRP_AW]};

    assign start = reg_wr && (reg_addr == A_CTRL) && reg_wdata[START_BIT] && !busy;

    regdrp_cfg #(.SEL_W(SEL_W)) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .wr_rstctl (reg_wr && (reg_addr == A_RSTCTL)),
        .wr_clksel (reg_wr && (reg_addr == A_CLKSEL)),
        .wdata_rst (reg_wdata[1:0]),
        .wdata_sel (reg_wdata[SEL_W-1:0]),
        .rstctl_q  (rstctl_q),
        .clksel_q  (clk_sel)
    );

    regdrp_engine eng_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd_in  (unpack_ctrl(reg_wdata)),
        .drp_rdy (drp_rdy),
        .drp_do  (drp_do),
        .busy    (busy),
        .cmd_q   (cmd_q),
        .rd_data (rd_data),
        .drp_en  (drp_en),
        .drp_we  (drp_we)
    );

    assign core_rel = rstctl_q[0];
    assign prim_en  = rstctl_q[1];
    assign drp_addr = cmd_q.addr;
    assign drp_di   = cmd_q.data;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_RSTCTL) begin
            reg_rdata[1:0] = rstctl_q;
        end else if (reg_addr == A_CLKSEL) begin
            reg_rdata[SEL_W-1:0] = clk_sel;
        end else if (reg_addr == A_CTRL) begin
            reg_rdata = pack_ctrl(cmd_q);
        end else if (reg_addr == A_STAT) begin
            reg_rdata[BUSY_BIT]     = busy;
            reg_rdata[DRP_DW-1:0]   = rd_data;
        end
    end
endmodule

module regdrp_bridge_chk
    import regdrp_pkg::*;
#(
    parameter int AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              busy,
    input logic [DRP_AW-1:0] drp_addr,
    input logic [DRP_DW-1:0] drp_di,
    input logic              drp_en,
    input logic              drp_we,
    input logic              drp_rdy
);
    logic ctrl_wr;
    assign ctrl_wr = reg_wr && (reg_addr == AW'(OFS_CTRL));

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[START_BIT] && !busy) |=> (drp_en && busy));

    // R4
    single_en_chk: assert property (@(posedge clk) disable iff (rst)
        drp_en |=> !drp_en);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !drp_rdy) |=> busy);

    // R5
    en_busy_chk: assert property (@(posedge clk) disable iff (rst)
        drp_en |-> busy);

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && busy) |=> !drp_en);

    // R7
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(drp_addr) && $stable(drp_di)));

    // R8
    no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !reg_wdata[START_BIT] && !busy) |=> !drp_en);

    // R6
    we_only_en_chk: assert property (@(posedge clk) disable iff (rst)
        drp_we |-> drp_en);
endmodule

bind regdrp_bridge regdrp_bridge_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .drp_addr  (drp_addr),
    .drp_di    (drp_di),
    .drp_en    (drp_en),
    .drp_we    (drp_we),
    .drp_rdy   (drp_rdy)
);

// File: tb/regdrp_bridge_tb.sv
module regdrp_bridge_tb_top;
    localparam int AW    = 8;
    localparam int SEL_W = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_rel, prim_en;
    logic [1:0]  clk_sel;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di;
    logic [15:0] drp_do = 16'hDEAD;
    logic        drp_en, drp_we;
    logic        drp_rdy = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int lat = 1;
    int pend = 0;
    logic [6:0] pend_addr = '0;
    logic [15:0] mem [128];

    // behavioural reference state
    int          m_phase = 0;  // 0 idle, 1 enable cycle, 2 waiting
    logic [1:0]  m_rst = '0;
    logic [1:0]  m_sel = '0;
    logic        m_rd = 1'b0;
    logic [6:0]  m_addr = '0;
    logic [15:0] m_data = '0;
    logic [15:0] m_rbuf = '0;

    always #5 clk = ~clk;

    regdrp_bridge #(.AW(AW), .SEL_W(SEL_W)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_rel(core_rel),
        .prim_en(prim_en), .clk_sel(clk_sel), .drp_addr(drp_addr),
        .drp_di(drp_di), .drp_do(drp_do), .drp_en(drp_en), .drp_we(drp_we),
        .drp_rdy(drp_rdy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h40: return {30'b0, m_rst};
            8'h44: return {30'b0, m_sel};
            8'h70: return {3'b0, m_rd, 5'b0, m_addr, m_data};
            8'h74: return {15'b0, (m_phase != 0), m_rbuf};
            default: return 32'h0;
        endcase
    endfunction

    // reference model update
    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_rst = '0; m_sel = '0; m_rd = 0;
            m_addr = '0; m_data = '0; m_rbuf = '0;
        end else begin
            if (m_phase == 1) m_phase = 2;
            else if (m_phase == 2 && drp_rdy) begin
                if (m_rd) m_rbuf = drp_do;
                m_phase = 0;
            end else if (m_phase == 0 && reg_wr && reg_addr == 8'h70 && reg_wdata[29]) begin
                m_phase = 1;
                m_rd = reg_wdata[28];
                m_addr = reg_wdata[22:16];
                m_data = reg_wdata[15:0];
            end
            if (reg_wr && reg_addr == 8'h40) m_rst = reg_wdata[1:0];
            if (reg_wr && reg_addr == 8'h44) m_sel = reg_wdata[1:0];
        end
    end

    // per-clock comparison, then responder
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 drp_en", {31'b0, drp_en}, {31'b0, m_phase == 1});
            chk("R6 drp_we", {31'b0, drp_we}, {31'b0, m_phase == 1 && !m_rd});
            chk("R9 drp_addr", {25'b0, drp_addr}, {25'b0, m_addr});
            chk("R4 drp_di", {16'b0, drp_di}, {16'b0, m_data});
            chk("R2 outputs", {30'b0, prim_en, core_rel}, {30'b0, m_rst});
            chk("R3 clk_sel", {30'b0, clk_sel}, {30'b0, m_sel});
            chk("R10 rdata", reg_rdata, exp_rd(reg_addr));
        end
        if (drp_rdy) begin
            drp_rdy <= 1'b0;
            drp_do  <= 16'hDEAD;
        end
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                drp_rdy <= 1'b1;
                drp_do  <= mem[pend_addr];
            end
        end
        if (drp_en) begin
            if (drp_we) mem[drp_addr] = drp_di;
            pend_addr = drp_addr;
            pend = lat;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        reg_addr = 8'h74;
        for (int i = 0; i < 100; i++) begin
            #1;
            if (!reg_rdata[16]) break;
            step();
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 16'(i * 3);
        repeat (3) step();
        rst = 1'b0;
        // R1: reset values
        rd_chk("R1 rstctl", 8'h40, 32'h0);
        rd_chk("R1 clksel", 8'h44, 32'h0);
        rd_chk("R1 ctrl", 8'h70, 32'h0);
        rd_chk("R1 status", 8'h74, 32'h0);
        chk("R1 outputs", {28'b0, drp_en, drp_we, prim_en, core_rel}, 32'h0);

        // R2
        wr(8'h40, 32'h1);
        chk("R2 rel only", {30'b0, prim_en, core_rel}, 32'h1);
        rd_chk("R2 readback", 8'h40, 32'h1);
        wr(8'h40, 32'hFFFF_FFFF);
        chk("R2 both", {30'b0, prim_en, core_rel}, 32'h3);
        rd_chk("R2 readback3", 8'h40, 32'h3);

        // R3
        wr(8'h44, 32'hFFFF_FFFD);
        chk("R3 sel", {30'b0, clk_sel}, 32'h1);
        rd_chk("R3 readback", 8'h44, 32'h1);

        // R4, R9: DRP write with junk in ignored bits, latency 3
        lat = 3;
        wr(8'h70, (32'h1 << 29) | (32'h1F << 23) | (32'h55 << 16) | 32'hBEEF);
        chk("R4 en pulse", {30'b0, drp_en, drp_we}, 32'h3);
        chk("R9 addr", {25'b0, drp_addr}, 32'h55);
        chk("R4 di", {16'b0, drp_di}, 32'hBEEF);
        rd_chk("R5 busy set", 8'h74, 32'h0001_0000);
        rd_chk("R9 ctrl readback", 8'h70, 32'h0055_BEEF);
        // R7: write while busy ignored
        wr(8'h70, (32'h1 << 29) | (32'h1 << 28) | (32'h12 << 16) | 32'h1111);
        chk("R7 no second pulse", {31'b0, drp_en}, 32'h0);
        chk("R7 addr kept", {25'b0, drp_addr}, 32'h55);
        rd_chk("R5 still busy", 8'h74, 32'h0001_0000);
        wait_idle();
        rd_chk("R6 write keeps data", 8'h74, 32'h0);

        // R6: read back, latency 1
        lat = 1;
        wr(8'h70, (32'h1 << 29) | (32'h1 << 28) | (32'h55 << 16) | 32'h0123);
        chk("R6 read no we", {30'b0, drp_en, drp_we}, 32'h2);
        wait_idle();
        rd_chk("R6 read data", 8'h74, 32'h0000_BEEF);

        // R6: read untouched address, latency 5
        lat = 5;
        wr(8'h70, (32'h1 << 29) | (32'h1 << 28) | (32'h7F << 16));
        step();
        rd_chk("R5 busy long", 8'h74, 32'h0001_BEEF);
        wait_idle();
        rd_chk("R6 read 7F", 8'h74, 32'h0000_017D);

        // R8: start flag clear
        wr(8'h70, (32'h1 << 28) | (32'h22 << 16) | 32'h4444);
        chk("R8 no pulse", {31'b0, drp_en}, 32'h0);
        rd_chk("R8 status idle", 8'h74, 32'h0000_017D);
        rd_chk("R8 ctrl kept", 8'h70, 32'h107F_0000);

        // R10: status write ignored
        wr(8'h74, 32'hFFFF_FFFF);
        rd_chk("R10 status write", 8'h74, 32'h0000_017D);

        // R11: unmapped
        rd_chk("R11 unmapped 48", 8'h48, 32'h0);
        rd_chk("R11 unmapped FF", 8'hFF, 32'h0);

        // R1: reset clears everything again
        rst = 1'b1;
        step();
        rst = 1'b0;
        rd_chk("R1 status after reset", 8'h74, 32'h0);
        rd_chk("R1 rstctl after reset", 8'h40, 32'h0);
        repeat (3) step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule